// File: doc/BRIEF.md
# Cache Line Refill Controller with Early Restart

This block fetches one data-cache line over a pipelined read bus after a miss. The line is split into eight beats. The refill starts at the beat that holds the requested word and wraps around the line, so that beat is always fetched first. When the acknowledgement for that first beat arrives, the requester gets its data and a one-cycle response pulse. It does not wait for the line to complete.

After the early response the controller keeps collecting the seven remaining acknowledgements into a register-array line buffer. A retried or new access is held off until the last beat lands. The in-flight request has already been answered at that point, but readiness depends only on the refill state and not on whether a request is still pending. Once the refill is complete, later requests to the same line are answered from the buffer without any bus traffic.

The states are as follows:
- IDLE: ready for a request.
- WAIT_CRIT: beats are being issued and the controller is waiting for the first acknowledgement.
- DRAIN: the early response has been given and the remaining beats are being collected.

The transitions are as follows:
- IDLE to WAIT_CRIT on a miss.
- IDLE to IDLE on a buffer hit.
- WAIT_CRIT to DRAIN on the first acknowledgement.
- DRAIN to IDLE on the eighth acknowledgement.

Top module: `refill_line_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `bus_cyc`, `bus_stb` and `resp_valid` are 0.
- R2: A miss produces exactly eight accepted strobes. The request's beat index is `req_addr[5:3]` and its line base is `req_addr` with bits 5:0 cleared. The k-th strobe carries the address line base + ((beat + k) mod 8) * 8, for k = 0 to 7.
- R3: A strobe is accepted in a cycle with `bus_stb`=1 and `bus_stall`=0. While the strobe is stalled, `bus_stb` and `bus_adr` hold. After the eighth acceptance no further strobe is raised.
- R4: `resp_valid` is 1 for exactly the one cycle after the first acknowledgement of a refill. In that cycle `resp_data` equals that acknowledgement's `bus_dat`.
- R5: After the early response the remaining seven acknowledgements are stored in order into the beats that follow, wrapping around the line. `bus_cyc` stays 1 until the cycle after the eighth acknowledgement.
- R6: `req_ready` is 0 from the cycle after a miss is accepted until the cycle after its eighth acknowledgement. A request held during that time causes no strobe and no response, and is not accepted before then.
- R7: Once a refill has completed, a request whose line base matches that line is answered in the next cycle with `resp_valid`=1 and the stored beat. No strobe is issued.
- R8: A request to any other line starts a new refill. The old line's contents are no longer used for responses.
- R9: `bus_cyc` is 1 exactly while a refill is in progress, which is the WAIT_CRIT and DRAIN states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an access |
| req_addr | input | 32 | Byte address of the access |
| req_ready | output | 1 | Controller can accept an access |
| resp_valid | output | 1 | One-cycle done pulse |
| resp_data | output | 64 | Data returned with the pulse |
| bus_cyc | output | 1 | Bus cycle active during a refill |
| bus_stb | output | 1 | Beat read strobe |
| bus_adr | output | 32 | Beat byte address |
| bus_stall | input | 1 | Slave refuses the strobe this cycle |
| bus_ack | input | 1 | Read acknowledgement, in issue order |
| bus_dat | input | 64 | Read data with acknowledgement |

## Verification
The bench holds a retried request on the port while a refill drains. A design that treated the early response as completion would accept that request before the last acknowledgement, and the bench would see a second refill or a response too early. Random stalls and acknowledgement gaps shift the early-response cycle, so a controller that responded a cycle late, responded on the wrong beat, or gave more than one pulse is caught by the cycle-by-cycle comparison. Misses that start at beat 0, at beat 7 and in the middle of the line exercise the wrap. Reading every beat back through buffer hits exposes data written to the wrong slot.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_WAIT_CRIT = 2'd1,
        S_DRAIN     = 2'd2
    } fill_state_e;
endpackage

// File: rtl/refill_issue.sv
module refill_issue #(
    parameter int ADDR_W     = 32,
    parameter int BEATS      = 8,
    parameter int BEAT_BYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(BEATS)-1:0] start_beat,
    input  logic [ADDR_W-1:0]        line_base,
    input  logic                     active,
    input  logic                     bus_stall,
    output logic                     bus_stb,
    output logic [ADDR_W-1:0]        bus_adr
);
    localparam int BW    = $clog2(BEATS);
    localparam int CW    = $clog2(BEATS + 1);
    localparam int OFF_W = $clog2(BEAT_BYTES);

    logic [CW-1:0]     sent_q;
    logic [BW-1:0]     beat_q;
    logic [ADDR_W-1:0] base_q;

    assign bus_stb = active && (sent_q < CW'(BEATS));
    assign bus_adr = base_q + (ADDR_W'(beat_q) << OFF_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= CW'(BEATS);
            beat_q <= '0;
            base_q <= '0;
        end else if (start) begin
            sent_q <= '0;
            beat_q <= start_beat;
            base_q <= line_base;
        end else if (bus_stb && !bus_stall) begin
            sent_q <= sent_q + 1'b1;
            beat_q <= beat_q + 1'b1;
        end
    end

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_stall && !start) |=> (bus_stb && $stable(bus_adr)));
    a_r3_issue_limit: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= CW'(BEATS));
endmodule

// File: rtl/refill_collect.sv
module refill_collect #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(BEATS)-1:0] start_beat,
    input  logic                     bus_ack,
    input  logic [DATA_W-1:0]        bus_dat,
    input  logic [$clog2(BEATS)-1:0] rd_beat,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     last_beat
);
    localparam int BW = $clog2(BEATS);
    localparam int CW = $clog2(BEATS + 1);

    logic [CW-1:0]     got_q;
    logic [BW-1:0]     fwd_beat_q;
    logic [DATA_W-1:0] line_mem [BEATS];

    assign last_beat = bus_ack && (got_q == CW'(BEATS - 1));
    assign rd_data   = line_mem[rd_beat];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q      <= CW'(BEATS);
            fwd_beat_q <= '0;
        end else if (start) begin
            got_q      <= '0;
            fwd_beat_q <= start_beat;
        end else if (bus_ack) begin
            got_q      <= got_q + 1'b1;
            fwd_beat_q <= fwd_beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (bus_ack) begin
            line_mem[fwd_beat_q] <= bus_dat;
        end
    end

    a_r5_ack_in_refill: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (got_q < CW'(BEATS)));
endmodule

// File: rtl/refill_line_ctrl.sv
module refill_line_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int BEATS      = 8,
    parameter int BEAT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic [ADDR_W-1:0] bus_adr,
    input  logic              bus_stall,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_dat
);
    import refill_pkg::*;

    localparam int OFF_W    = $clog2(BEAT_BYTES);
    localparam int BW       = $clog2(BEATS);
    localparam int LINE_OFF = OFF_W + BW;

    fill_state_e       state_q, state_d;
    logic [ADDR_W-1:0] line_q;
    logic              buf_valid_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    logic [ADDR_W-1:0] req_line;
    logic [BW-1:0]     req_beat;
    logic              accept, hit, start, last_beat;
    logic [DATA_W-1:0] rd_data;

    assign req_line  = {req_addr[ADDR_W-1:LINE_OFF], LINE_OFF'(0)};
    assign req_beat  = req_addr[LINE_OFF-1:OFF_W];
    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit       = buf_valid_q && (req_line == line_q);
    assign start     = accept && !hit;
    assign bus_cyc   = (state_q != S_IDLE);
    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

    refill_issue #(
        .ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .start(start), .start_beat(req_beat),
        .line_base(req_line), .active(bus_cyc), .bus_stall(bus_stall),
        .bus_stb(bus_stb), .bus_adr(bus_adr)
    );

    refill_collect #(
        .DATA_W(DATA_W), .BEATS(BEATS)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .start(start), .start_beat(req_beat),
        .bus_ack(bus_ack), .bus_dat(bus_dat), .rd_beat(req_beat),
        .rd_data(rd_data), .last_beat(last_beat)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start)     state_d = S_WAIT_CRIT;
            S_WAIT_CRIT: if (bus_ack)   state_d = S_DRAIN;
            S_DRAIN:     if (last_beat) state_d = S_IDLE;
            default:                    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            buf_valid_q  <= 1'b0;
            line_q       <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            if (accept && hit) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= rd_data;
            end else if (state_q == S_WAIT_CRIT && bus_ack) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= bus_dat;
            end
            if (start) begin
                buf_valid_q <= 1'b0;
                line_q      <= req_line;
            end else if (state_q == S_DRAIN && last_beat) begin
                buf_valid_q <= 1'b1;
            end
        end
    end

    a_r4_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_CRIT && bus_ack) |=> (resp_valid && state_q == S_DRAIN));
    a_r5_cyc_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !last_beat && !(state_q == S_IDLE)) |=> bus_cyc);
    a_r8_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!buf_valid_q && !req_ready));
    a_r6_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !last_beat) |=> !req_ready);
endmodule

// File: tb/refill_line_ctrl_test.sv
module refill_line_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, bus_cyc, bus_stb;
    logic [63:0] resp_data;
    logic [31:0] bus_adr;
    logic        bus_stall = 1'b0;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_dat = '0;

    int checks = 0;
    int errors = 0;
    int ncount = 0;

    always #4 clk = ~clk;

    refill_line_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_adr(bus_adr),
        .bus_stall(bus_stall), .bus_ack(bus_ack), .bus_dat(bus_dat)
    );

    function automatic logic [63:0] dval(input logic [31:0] a);
        return {a ^ 32'h5A5A_0F0F, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slave model
    logic [31:0] q_addr[$];
    int          q_due[$];
    int          last_due = 0;

    always @(posedge clk) begin
        #1;
        bus_ack   = 1'b0;
        bus_stall = ($urandom_range(0, 3) == 0);
        if (q_addr.size() > 0 && q_due[0] <= ncount) begin
            bus_ack = 1'b1;
            bus_dat = dval(q_addr[0]);
            void'(q_addr.pop_front());
            void'(q_due.pop_front());
        end
    end

    // reference model
    bit          m_busy = 0, m_buf_valid = 0, exp_rv = 0;
    int          m_issued = 0, m_acks = 0, m_start = 0;
    logic [31:0] m_base = '0, m_line = '0;
    logic [63:0] m_buf [8];
    logic [63:0] exp_rd = '0;
    int          acked_beats[$];

    always @(negedge clk) begin
        ncount++;
        if (rst_n) begin
            logic [31:0] eadr;
            logic [31:0] rline;
            int          rbeat;
            eadr = m_base + 32'((m_start + m_issued) % 8) * 8;
            chk(req_ready == !m_busy, "R6", 64'(req_ready), 64'(!m_busy));
            chk(bus_cyc == m_busy, "R9", 64'(bus_cyc), 64'(m_busy));
            chk(resp_valid == exp_rv, "R4", 64'(resp_valid), 64'(exp_rv));
            if (exp_rv) chk(resp_data == exp_rd, "R4/R7 data", resp_data, exp_rd);
            if (m_busy && m_issued < 8) begin
                chk(bus_stb === 1'b1, "R3", 64'(bus_stb), 64'd1);
                chk(bus_adr == eadr, "R2", 64'(bus_adr), 64'(eadr));
            end else begin
                chk(bus_stb === 1'b0, "R3", 64'(bus_stb), 64'd0);
            end
            // advance to next cycle
            exp_rv = 0;
            rline  = {req_addr[31:6], 6'd0};
            rbeat  = int'(req_addr[5:3]);
            if (!m_busy) begin
                if (req_valid) begin
                    if (m_buf_valid && rline == m_line) begin
                        exp_rv = 1;
                        exp_rd = m_buf[rbeat];
                    end else begin
                        m_busy = 1; m_buf_valid = 0; m_base = rline; m_line = rline;
                        m_start = rbeat; m_issued = 0; m_acks = 0;
                        acked_beats.delete();
                    end
                end
            end else begin
                if (m_issued < 8 && !bus_stall) begin
                    int d;
                    d = ncount + $urandom_range(0, 3);
                    if (d < last_due) d = last_due;
                    last_due = d;
                    q_addr.push_back(eadr);
                    q_due.push_back(d);
                    m_issued++;
                end
                if (bus_ack) begin
                    int b;
                    b = (m_start + m_acks) % 8;
                    m_buf[b] = dval(m_base + 32'(b) * 8);
                    acked_beats.push_back(b);
                    if (m_acks == 0) begin
                        exp_rv = 1;
                        exp_rd = m_buf[b];
                    end
                    m_acks++;
                    if (m_acks == 8) begin
                        bit ord_ok;
                        ord_ok = 1;
                        foreach (acked_beats[i]) if (acked_beats[i] != (m_start + i) % 8) ord_ok = 0;
                        chk(ord_ok, "R2 order", 64'(acked_beats.size()), 64'd8);
                        chk(m_issued == 8, "R5 count", 64'(m_issued), 64'd8);
                        m_busy = 0;
                        m_buf_valid = 1;
                    end
                end
            end
        end
    end

    // requester driver
    task automatic do_req(input logic [31:0] a, input bit release_after);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = a;
        do @(negedge clk); while (!req_ready);
        if (release_after) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (40) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(bus_cyc === 1'b0 && bus_stb === 1'b0, "R1 bus", 64'({bus_cyc, bus_stb}), 64'd0);
        chk(resp_valid === 1'b0, "R1 resp", 64'(resp_valid), 64'd0);

        // R2/R4 miss at beat 3, then R6 retry held during drain, accepted as R7 hit
        do_req(32'h1000_0018, 1'b0);
        @(posedge clk); #1;
        req_addr = 32'h1000_0030;
        @(negedge clk);
        chk(req_ready === 1'b0, "R6 held off", 64'(req_ready), 64'd0);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1 req_valid = 1'b0;
        settle();

        // R7: read every beat of the line back from the buffer
        for (int b = 0; b < 8; b++) begin
            do_req(32'h1000_0000 + 32'(b) * 8, 1'b1);
            repeat (2) @(posedge clk);
        end

        // R8: other line, beat 0 and beat 7 misses
        do_req(32'h2000_0040, 1'b1);
        settle();
        do_req(32'h2000_00B8, 1'b1);
        settle();
        do_req(32'h2000_0048, 1'b1);
        settle();
        do_req(32'h2000_0040, 1'b1);
        settle();

        // mixed random traffic
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            a = 32'h3000_0000 + 32'($urandom_range(0, 3)) * 64 + 32'($urandom_range(0, 7)) * 8;
            do_req(a, $urandom_range(0, 1) == 1);
        end
        req_valid = 1'b0;
        settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (ncount > 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", ncount, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule